// File: doc/BRIEF.md
# SD Host Error Status Capture

This block sits beside the command and data engines of an SD host controller and turns their per-transfer check results into a small set of sticky error flags that software reads. A command engine says when a command has gone out and when a response start bit is seen. The block times the gap between the two in card-clock cycles and flags a missing response when the gap grows too long. It also latches a bad response CRC and a bad read-data CRC, which arrive as check results. After a write data block it decodes the card's CRC status token on DAT0 and flags a write the card did not accept.

Software clears flags by writing ones over the bits it has handled. A mask selects which flags may raise the single interrupt output. Clock gating of the card clock is modelled by a per-cycle enable. The response window and the token decoder advance only on cycles where the card clock actually ran.

Top module: `sd_err_capture`

## Requirements
- R1: After a synchronous reset, `status` reads 0x0000 and `irq` reads 0.
- R2: A cycle with `rd_done` and `rd_crc_bad` both high sets status bit 0 (value 0x01) at the next clock edge. `rd_done` with `rd_crc_bad` low changes no bit.
- R3: A cycle with `rsp_done` and `rsp_crc_bad` both high sets status bit 4 (value 0x10) at the next clock edge. `rsp_done` with `rsp_crc_bad` low changes no bit.
- R4: Status bit 3 (value 0x08) is set when 8 ticking cycles pass after a `cmd_end` cycle with no `rsp_start` in any of them. It is set at the edge that ends the 8th ticking cycle. A `rsp_start` in or before that 8th ticking cycle leaves bit 3 clear.
- R5: Only cycles with `clk_tick` high advance the response window. Cycles with `clk_tick` low, however many, neither add to the window nor declare a missing response.
- R6: After a `wr_done` cycle, the decoder waits for the first ticking cycle with `dat0` low, which is the token start bit. It takes that bit and the next four ticking samples as a 5-bit token, first bit as MSB. The token 5'b00101 leaves status bit 1 clear. The token 5'b01011 sets status bit 1 (value 0x02) at the edge that ends the last token bit.
- R7: Any other 5-bit token that begins with a low start bit, such as 5'b01101 or 5'b00000, also sets status bit 1.
- R8: Each error bit stays set until software clears it. A cycle with `clr_we` high clears exactly the bits where `clr_data` is 1. If a bit is set and cleared in the same cycle, it ends up set.
- R9: Status bits 2, 5, 6, 7 and every bit above bit 7 always read 0. This holds even while errors fire and clears are written to those bits.
- R10: `irq` is high exactly when some status bit is 1 and its `irq_mask` bit is 0, where a mask bit of 1 blocks that flag. `irq` is registered: it changes at the same edge as `status`, and a mask change reaches `irq` one edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, one cycle per card-clock slot |
| rst | input | 1 | Synchronous active-high reset |
| clk_tick | input | 1 | High in cycles where the card clock ran |
| cmd_end | input | 1 | Pulse: command end bit sent, response expected |
| rsp_start | input | 1 | Pulse: response start bit detected on CMD |
| rsp_done | input | 1 | Pulse: response received, CRC result valid |
| rsp_crc_bad | input | 1 | Response CRC mismatch, qualified by rsp_done |
| rd_done | input | 1 | Pulse: read block received, CRC result valid |
| rd_crc_bad | input | 1 | Read-data CRC mismatch, qualified by rd_done |
| wr_done | input | 1 | Pulse: write data block fully sent |
| dat0 | input | 1 | DAT0 line level |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | STAT_W (16) | Bits to clear when clr_we is high |
| irq_mask | input | STAT_W (16) | Per-bit interrupt mask, 1 blocks the flag |
| status | output | STAT_W (16) | Sticky error flags |
| irq | output | 1 | Interrupt, OR of unmasked flags |

## Verification
The properties assume that `rsp_crc_bad` and `rd_crc_bad` are only meaningful while their `done` strobes are high. They also assume the mask is held steady except where a test changes it on purpose. The stimulus drives every pulse for exactly one cycle and holds `dat0` high outside token bits, so hunting never starts on a stray low. It places each token's bits on consecutive ticking cycles. Window tests hold `clk_tick` low for chosen stretches to show that stopped-clock cycles are not counted. The response start is put exactly on the last allowed ticking cycle to probe the boundary.

// File: rtl/sd_err_pkg.sv
package sd_err_pkg;
  localparam int unsigned BIT_RD_CRC  = 0;
  localparam int unsigned BIT_WR_CRC  = 1;
  localparam int unsigned BIT_NO_RSP  = 3;
  localparam int unsigned BIT_RSP_CRC = 4;

  localparam int unsigned TOK_LEN = 5;
  localparam logic [TOK_LEN-1:0] TOK_ACCEPT  = 5'b00101;
  localparam logic [TOK_LEN-1:0] TOK_CRC_ERR = 5'b01011;

  typedef enum logic [1:0] {
    TK_IDLE  = 2'd0,
    TK_HUNT  = 2'd1,
    TK_SHIFT = 2'd2
  } tok_state_e;
endpackage

// File: rtl/sd_rsp_watch.sv
module sd_rsp_watch #(
  parameter int unsigned RSP_WIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_tick,
  input  logic cmd_end,
  input  logic rsp_start,
  output logic no_rsp
);
  localparam int unsigned CNT_W = (RSP_WIN < 2) ? 1 : $clog2(RSP_WIN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RSP_WIN - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  // window closes on the last ticking slot with no start bit
  assign expire = armed_q && !cmd_end && !rsp_start && clk_tick && (cnt_q == LAST);
  assign no_rsp = expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cmd_end) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (rsp_start) begin
        armed_q <= 1'b0;
      end else if (clk_tick) begin
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sd_wtok_decode.sv
module sd_wtok_decode
  import sd_err_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clk_tick,
  input  logic wr_done,
  input  logic dat0,
  output logic tok_bad
);
  localparam int unsigned BC_W = $clog2(TOK_LEN);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(TOK_LEN - 1);

  tok_state_e           st_q;
  logic [TOK_LEN-2:0]   sh_q;
  logic [BC_W-1:0]      bc_q;
  logic [TOK_LEN-1:0]   word;
  logic                 finish;

  assign word   = {sh_q, dat0};
  assign finish = (st_q == TK_SHIFT) && clk_tick && !wr_done && (bc_q == BC_LAST);
  // anything other than the accept pattern counts as a rejected write
  assign tok_bad = finish && (word != TOK_ACCEPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= TK_IDLE;
      sh_q <= '0;
      bc_q <= '0;
    end else if (wr_done) begin
      st_q <= TK_HUNT;
      sh_q <= '0;
      bc_q <= '0;
    end else begin
      case (st_q)
        TK_HUNT: begin
          if (clk_tick && !dat0) begin
            st_q <= TK_SHIFT;
            sh_q <= '0;
            bc_q <= BC_W'(1);
          end
        end
        TK_SHIFT: begin
          if (clk_tick) begin
            if (bc_q == BC_LAST) begin
              st_q <= TK_IDLE;
            end else begin
              sh_q <= {sh_q[TOK_LEN-3:0], dat0};
              bc_q <= bc_q + 1'b1;
            end
          end
        end
        default: st_q <= TK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_err_status.sv
module sd_err_status #(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_data,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_nxt;
  logic [STAT_W-1:0] clr_vec;

  assign clr_vec = clr_we ? clr_data : '0;

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_bit
      // a fresh error outranks a clear in the same cycle
      assign stat_nxt[gi] = (stat_q[gi] & ~clr_vec[gi]) | set_vec[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      irq    <= |(stat_nxt & ~irq_mask);
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/sd_err_capture.sv
module sd_err_capture
  import sd_err_pkg::*;
#(
  parameter int unsigned STAT_W  = 16,
  parameter int unsigned RSP_WIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_tick,
  input  logic              cmd_end,
  input  logic              rsp_start,
  input  logic              rsp_done,
  input  logic              rsp_crc_bad,
  input  logic              rd_done,
  input  logic              rd_crc_bad,
  input  logic              wr_done,
  input  logic              dat0,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_data,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic              no_rsp;
  logic              tok_bad;
  logic [STAT_W-1:0] set_vec;

  sd_rsp_watch #(.RSP_WIN(RSP_WIN)) u_rsp (
    .clk(clk), .rst(rst), .clk_tick(clk_tick),
    .cmd_end(cmd_end), .rsp_start(rsp_start), .no_rsp(no_rsp)
  );

  sd_wtok_decode u_tok (
    .clk(clk), .rst(rst), .clk_tick(clk_tick),
    .wr_done(wr_done), .dat0(dat0), .tok_bad(tok_bad)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[BIT_RD_CRC]  = rd_done && rd_crc_bad;
    set_vec[BIT_WR_CRC]  = tok_bad;
    set_vec[BIT_NO_RSP]  = no_rsp;
    set_vec[BIT_RSP_CRC] = rsp_done && rsp_crc_bad;
  end

  sd_err_status #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_we(clr_we), .clr_data(clr_data), .irq_mask(irq_mask),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/sd_err_capture_chk.sv
module sd_err_capture_chk #(
  parameter int unsigned STAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_done,
  input logic              rsp_crc_bad,
  input logic              rd_done,
  input logic              rd_crc_bad,
  input logic              clr_we,
  input logic [STAT_W-1:0] clr_data,
  input logic [STAT_W-1:0] irq_mask,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  localparam logic [STAT_W-1:0] LIVE = STAT_W'(16'h001B);

  AST_RD_CRC_SET: assert property (@(posedge clk) disable iff (rst)
    (rd_done && rd_crc_bad) |=> status[0]); // R2

  AST_RSP_CRC_SET: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_crc_bad) |=> status[4]); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(status) & ~($past(clr_we) ? $past(clr_data) : '0)) & ~status) == '0)); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status & ~LIVE) == '0)); // R9

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(status & ~$past(irq_mask)))); // R10
endmodule

bind sd_err_capture sd_err_capture_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .rsp_done(rsp_done), .rsp_crc_bad(rsp_crc_bad),
  .rd_done(rd_done), .rd_crc_bad(rd_crc_bad), .clr_we(clr_we),
  .clr_data(clr_data), .irq_mask(irq_mask), .status(status), .irq(irq)
);

// File: tb/sd_err_capture_tb_top.sv
module sd_err_capture_tb_top;
  localparam int STAT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_tick = 1'b1;
  logic cmd_end = 1'b0, rsp_start = 1'b0, rsp_done = 1'b0, rsp_crc_bad = 1'b0;
  logic rd_done = 1'b0, rd_crc_bad = 1'b0, wr_done = 1'b0, dat0 = 1'b1;
  logic clr_we = 1'b0;
  logic [STAT_W-1:0] clr_data = '0;
  logic [STAT_W-1:0] irq_mask = '0;
  logic [STAT_W-1:0] status;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sd_err_capture #(.STAT_W(STAT_W), .RSP_WIN(8)) dut_i (
    .clk(clk), .rst(rst), .clk_tick(clk_tick), .cmd_end(cmd_end),
    .rsp_start(rsp_start), .rsp_done(rsp_done), .rsp_crc_bad(rsp_crc_bad),
    .rd_done(rd_done), .rd_crc_bad(rd_crc_bad), .wr_done(wr_done),
    .dat0(dat0), .clr_we(clr_we), .clr_data(clr_data), .irq_mask(irq_mask),
    .status(status), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_data = '1; step(1);
    clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic send_tok(input logic [4:0] tok);
    wr_done = 1'b1; step(1); wr_done = 1'b0;
    dat0 = 1'b1; step(2);
    for (int i = 4; i >= 0; i--) begin
      dat0 = tok[i]; step(1);
    end
    dat0 = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_read_crc();
    rd_done = 1'b1; rd_crc_bad = 1'b0; step(1); rd_done = 1'b0;
    chk("R2 good read", status, 0);
    rd_done = 1'b1; rd_crc_bad = 1'b1; step(1); rd_done = 1'b0; rd_crc_bad = 1'b0;
    chk("R2 bad read", status, 16'h0001);
    chk("R10 irq unmasked", irq, 1);
    clear_all();
    chk("R8 clear all", status, 0);
  endtask

  task automatic t_rsp_crc();
    rsp_done = 1'b1; rsp_crc_bad = 1'b0; step(1); rsp_done = 1'b0;
    chk("R3 good rsp", status, 0);
    rsp_done = 1'b1; rsp_crc_bad = 1'b1; step(1); rsp_done = 1'b0; rsp_crc_bad = 1'b0;
    chk("R3 bad rsp", status, 16'h0010);
    clear_all();
  endtask

  task automatic t_no_rsp();
    cmd_end = 1'b1; step(1); cmd_end = 1'b0;
    step(7);
    chk("R4 before 8th tick", status, 0);
    step(1);
    chk("R4 after 8th tick", status, 16'h0008);
    clear_all();
    cmd_end = 1'b1; step(1); cmd_end = 1'b0;
    step(7);
    rsp_start = 1'b1; step(1); rsp_start = 1'b0;
    step(4);
    chk("R4 start on 8th tick", status, 0);
    cmd_end = 1'b1; step(1); cmd_end = 1'b0;
    step(3);
    rsp_start = 1'b1; step(1); rsp_start = 1'b0;
    step(10);
    chk("R4 early start", status, 0);
  endtask

  task automatic t_tick_gate();
    cmd_end = 1'b1; step(1); cmd_end = 1'b0;
    step(3);
    clk_tick = 1'b0; step(20); clk_tick = 1'b1;
    step(4);
    chk("R5 stopped clock not counted", status, 0);
    step(1);
    chk("R5 expire on 8th tick", status, 16'h0008);
    clear_all();
  endtask

  task automatic t_tokens();
    send_tok(5'b00101);
    step(1);
    chk("R6 accepted token", status, 0);
    send_tok(5'b01011);
    chk("R6 crc token", status, 16'h0002);
    clear_all();
    send_tok(5'b01101);
    chk("R7 unknown token", status, 16'h0002);
    clear_all();
    send_tok(5'b00000);
    chk("R7 all-zero token", status, 16'h0002);
    clear_all();
  endtask

  task automatic t_w1c();
    rd_done = 1'b1; rd_crc_bad = 1'b1; rsp_done = 1'b1; rsp_crc_bad = 1'b1; step(1);
    rd_done = 1'b0; rd_crc_bad = 1'b0; rsp_done = 1'b0; rsp_crc_bad = 1'b0;
    step(3);
    chk("R8 sticky", status, 16'h0011);
    clr_we = 1'b1; clr_data = 16'h0010; step(1); clr_we = 1'b0; clr_data = '0;
    chk("R8 partial clear", status, 16'h0001);
    rd_done = 1'b1; rd_crc_bad = 1'b1; clr_we = 1'b1; clr_data = 16'h0001; step(1);
    rd_done = 1'b0; rd_crc_bad = 1'b0; clr_we = 1'b0; clr_data = '0;
    chk("R8 set beats clear", status, 16'h0001);
    clear_all();
  endtask

  task automatic t_reserved_irq();
    rd_done = 1'b1; rd_crc_bad = 1'b1; rsp_done = 1'b1; rsp_crc_bad = 1'b1; step(1);
    rd_done = 1'b0; rd_crc_bad = 1'b0; rsp_done = 1'b0; rsp_crc_bad = 1'b0;
    cmd_end = 1'b1; step(1); cmd_end = 1'b0; step(8);
    send_tok(5'b01011);
    chk("R9 only live bits", status, 16'h001B);
    clr_we = 1'b1; clr_data = 16'hFFE4; step(1); clr_we = 1'b0; clr_data = '0;
    chk("R9 reserved clear no effect", status, 16'h001B);
    irq_mask = 16'h001B; step(1);
    chk("R10 all masked", irq, 0);
    irq_mask = 16'h0013; step(1);
    chk("R10 one unmasked", irq, 1);
    clr_we = 1'b1; clr_data = 16'h0008; step(1); clr_we = 1'b0; clr_data = '0;
    chk("R10 unmasked bit cleared", irq, 0);
    irq_mask = '0;
    clear_all();
    chk("R10 idle irq", irq, 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_read_crc();
    t_rsp_crc();
    t_no_rsp();
    t_tick_gate();
    t_tokens();
    t_w1c();
    t_reserved_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule